// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the strobes and the multiplexed address/data traffic that an 8-bit microcontroller core uses to reach off-chip code and data memory. It runs directly on the oscillator clock. A machine cycle lasts twelve oscillator clocks, built from six states of two clocks each. In every machine cycle the block emits the address-latch strobe, the code-read strobe, or the data read/write strobes. It drives the low address byte and then the data byte on a shared bus, and it drives the high address byte on a separate port.

The core issues one request per machine cycle through a small interface: a 3-bit kind, an address, write data, the current high-port latch value, and two mode levels. The mode levels say whether code runs from external memory and whether the address-latch strobe should be quiet. The block samples the request at the end of the last clock of each machine cycle. It marks that clock on `mc_sync`. Bytes read back from the bus are returned on `rbyte` with a one-clock valid pulse.

Top module: `xbus_sequencer`

## Requirements
- R1: While `rst` is high and in the first clock after it falls, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe` is 0, `rbyte_vld` is 0 and `mc_sync` is 1.
- R2: A machine cycle is 12 clocks, numbered slot 0 to slot 11. `mc_sync` is 1 in slot 11 only. The request inputs present in that clock govern the next 12 slots. Kind codes: 0 idle, 1 fetch, 2 table read, 3 reserved (acts as idle), 4 read with 8-bit address, 5 read with 16-bit address, 6 write with 8-bit address, 7 write with 16-bit address.
- R3: In idle and reserved cycles, with the quiet level clear or external execution set, `ale` is 1 in slots 0, 1, 6 and 7 and 0 elsewhere. No other strobe is active.
- R4: In a data cycle (kinds 4 to 7), `ale` is 1 in slots 0 and 1 only, so the second pulse is dropped. `psen_n` stays 1, so both code strobes are dropped. `rd_n` (reads) or `wr_n` (writes) is 0 in slots 3 to 8, six clocks.
- R5: In a fetch cycle with external execution set, `psen_n` is 0 in slots 3 to 5 and 9 to 11. The bus carries the low byte of `req_addr` in slots 0 and 1 and the low byte of `req_addr+1` in slots 6 and 7. `ale` pulses in both halves.
- R6: With `ale_quiet` set and external execution clear, `ale` stays 0 through idle and fetch cycles. It still pulses in data cycles (slots 0 and 1) and in table-read cycles (both halves).
- R7: With external execution set, `ale_quiet` has no effect on `ale`.
- R8: The bus drives the low address byte in every slot where an external address is emitted. On writes it drives `req_wdata` in slots 2 to 10. It is released (`ad_oe`=0) in all other slots, including whenever a read strobe is low.
- R9: `hi_out` gives the high address byte for external fetches, which is taken from `req_addr+1` in slots 6 to 11. It also gives the high address byte for table reads and for 16-bit data addressing. For 8-bit data addressing, idle and internal fetch it gives the latched `port_hi_latch` value.
- R10: `rbyte_vld` pulses for one clock with the bus byte sampled in the last low-strobe slot. For data reads, the byte sampled in slot 8 is shown in slot 9. For code reads, the byte sampled in slot 5 is shown in slot 6, and the byte sampled in slot 11 is shown in slot 0 of the next cycle.
- R11: A table-read cycle makes one code read: `psen_n` is 0 in slots 3 to 5 only, the address goes out in slots 0 and 1, and `hi_out` holds the high byte throughout.
- R12: A fetch with external execution clear is internal: `psen_n` stays 1 and `ad_oe` stays 0 for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_exec | input | 1 | Code runs from external memory |
| ale_quiet | input | 1 | Quiet the address-latch strobe outside data and table-read cycles |
| req_kind | input | 3 | Request kind for the next machine cycle |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| port_hi_latch | input | DATA_W | High-port latch contents |
| ad_in | input | DATA_W | Bus value read from the pads |
| mc_sync | output | 1 | Last slot of a machine cycle, request sampled |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Code-read strobe, active low |
| rd_n | output | 1 | Data-read strobe, active low |
| wr_n | output | 1 | Data-write strobe, active low |
| ad_out | output | DATA_W | Bus output value |
| ad_oe | output | 1 | Bus output enable |
| hi_out | output | DATA_W | High address port |
| rbyte | output | DATA_W | Byte returned from a read |
| rbyte_vld | output | 1 | `rbyte` valid pulse |

## Verification
Every request kind is run with each mix of the quiet level and external execution. This separates the strobe-dropping rules, the quiet rule and its override, and internal from external fetch. A fetch at an address ending in FF shows that the second half carries the incremented address into the high byte. An 8-bit data access whose high address byte differs from the latch value shows which source drives the high port. Back-to-back fetch and read cycles confirm that the second code byte lands in the next cycle's first slot. A long seeded random run then mixes kinds, addresses, bus data and modes against the slot-by-slot model.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   typedef enum logic [2:0] {
      XK_IDLE  = 3'd0,
      XK_FETCH = 3'd1,
      XK_MOVC  = 3'd2,
      XK_RSVD  = 3'd3,
      XK_RD8   = 3'd4,
      XK_RD16  = 3'd5,
      XK_WR8   = 3'd6,
      XK_WR16  = 3'd7
   } xkind_e;

   // decoded per-cycle behaviour
   typedef struct packed {
      logic data;    // external data access
      logic wr;      // data write
      logic wide;    // 16-bit data address
      logic xfetch;  // external instruction fetch
      logic movc;    // table read from code space
      logic sup;     // address strobe quieted
   } xcyc_t;

   function automatic xcyc_t xcyc_decode(input logic [2:0] kind,
                                         input logic quiet,
                                         input logic ext);
      xcyc_t c;
      c.data   = kind[2];
      c.wr     = kind[2] & kind[1];
      c.wide   = kind[2] & kind[0];
      c.xfetch = (kind == XK_FETCH) & ext;
      c.movc   = (kind == XK_MOVC);
      c.sup    = quiet & ~ext;
      return c;
   endfunction

endpackage

// File: rtl/xbus_phase.sv
module xbus_phase #(
   parameter  int STATE_CLKS = 2,
   localparam int CYC        = 6 * STATE_CLKS,
   localparam int PW         = $clog2(CYC + 1)
) (
   input  logic          clk,
   input  logic          rst,
   output logic [PW-1:0] phase,
   output logic [PW-1:0] phase_nxt,
   output logic          wrap,
   output logic          mc_sync
);

   localparam logic [PW-1:0] LAST = PW'(CYC - 1);

   always_comb begin
      wrap      = (phase == LAST);
      phase_nxt = wrap ? '0 : phase + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase   <= LAST;
         mc_sync <= 1'b1;
      end else begin
         phase   <= phase_nxt;
         mc_sync <= (phase_nxt == LAST);
      end
   end

   // R2
   sync_single_chk: assert property (@(posedge clk) disable iff (rst)
      mc_sync |=> !mc_sync);

endmodule

// File: rtl/xbus_req_latch.sv
module xbus_req_latch
   import xbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wrap,
   input  logic [2:0]        kind,
   input  logic              quiet,
   input  logic              ext,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] p2,
   output xcyc_t             cyc_q,
   output xcyc_t             cyc_d,
   output logic [ADDR_W-1:0] addr_q,
   output logic [ADDR_W-1:0] addr_d,
   output logic [DATA_W-1:0] wd_q,
   output logic [DATA_W-1:0] wd_d,
   output logic [DATA_W-1:0] p2_q,
   output logic [DATA_W-1:0] p2_d
);

   xcyc_t cyc_in;

   always_comb begin
      cyc_in = xcyc_decode(kind, quiet, ext);
      cyc_d  = wrap ? cyc_in : cyc_q;
      addr_d = wrap ? addr   : addr_q;
      wd_d   = wrap ? wdata  : wd_q;
      p2_d   = wrap ? p2     : p2_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc_q  <= xcyc_decode(XK_IDLE, 1'b0, 1'b0);
         addr_q <= '0;
         wd_q   <= '0;
         p2_q   <= '0;
      end else begin
         cyc_q  <= cyc_d;
         addr_q <= addr_d;
         wd_q   <= wd_d;
         p2_q   <= p2_d;
      end
   end

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
   import xbus_pkg::*;
#(
   parameter  int STATE_CLKS = 2,
   parameter  int ADDR_W     = 16,
   parameter  int DATA_W     = 8,
   parameter  bit REG_PINS   = 1'b1,
   localparam int CYC        = 6 * STATE_CLKS,
   localparam int PW         = $clog2(CYC + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PW-1:0]     phase,
   input  logic [PW-1:0]     phase_nxt,
   input  xcyc_t             cyc_q,
   input  xcyc_t             cyc_d,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic [DATA_W-1:0] wd_q,
   input  logic [DATA_W-1:0] wd_d,
   input  logic [DATA_W-1:0] p2_q,
   input  logic [DATA_W-1:0] p2_d,
   output logic              ale,
   output logic              psen_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [DATA_W-1:0] hi_out
);

   localparam int HALF_CLKS = 3 * STATE_CLKS;
   localparam logic [PW-1:0] T_ALE  = PW'(STATE_CLKS);
   localparam logic [PW-1:0] T_HALF = PW'(HALF_CLKS);
   localparam logic [PW-1:0] T_A2E  = PW'(HALF_CLKS + STATE_CLKS);
   localparam logic [PW-1:0] T_PSB  = PW'(STATE_CLKS + STATE_CLKS / 2);
   localparam logic [PW-1:0] T_PS2B = PW'(HALF_CLKS + STATE_CLKS + STATE_CLKS / 2);
   localparam logic [PW-1:0] T_STE  = PW'(4 * STATE_CLKS + STATE_CLKS / 2);
   localparam logic [PW-1:0] T_WDE  = PW'(5 * STATE_CLKS + STATE_CLKS / 2);

   logic [PW-1:0]     ph;
   xcyc_t             c;
   logic [ADDR_W-1:0] a, a_inc;
   logic [DATA_W-1:0] w, p;
   logic in_a1, in_a2, psw1, psw2, stb_w, wd_w, ale_h1, ale_h2;
   logic              n_ale, n_psen_n, n_rd_n, n_wr_n, n_oe;
   logic [DATA_W-1:0] n_ad, n_hi;

   always_comb begin
      ph     = REG_PINS ? phase_nxt : phase;
      c      = REG_PINS ? cyc_d     : cyc_q;
      a      = REG_PINS ? addr_d    : addr_q;
      w      = REG_PINS ? wd_d      : wd_q;
      p      = REG_PINS ? p2_d      : p2_q;
      a_inc  = a + 1'b1;

      in_a1  = (ph < T_ALE);
      in_a2  = (ph >= T_HALF) && (ph < T_A2E);
      psw1   = (ph >= T_PSB) && (ph < T_HALF);
      psw2   = (ph >= T_PS2B);
      stb_w  = (ph >= T_PSB) && (ph < T_STE);
      wd_w   = (ph >= T_ALE) && (ph < T_WDE);

      ale_h1 = c.data | c.movc | ~c.sup;
      ale_h2 = ~c.data & (c.movc | ~c.sup);

      n_ale    = (in_a1 & ale_h1) | (in_a2 & ale_h2);
      n_psen_n = ~((c.xfetch & (psw1 | psw2)) | (c.movc & psw1));
      n_rd_n   = ~(c.data & ~c.wr & stb_w);
      n_wr_n   = ~(c.data &  c.wr & stb_w);

      n_oe = 1'b0;
      n_ad = '0;
      n_hi = p;
      if (c.data) begin
         if (c.wide) n_hi = a[ADDR_W-1 -: DATA_W];
         if (in_a1) begin
            n_oe = 1'b1;
            n_ad = a[DATA_W-1:0];
         end else if (c.wr && wd_w) begin
            n_oe = 1'b1;
            n_ad = w;
         end
      end else if (c.xfetch) begin
         n_hi = (ph < T_HALF) ? a[ADDR_W-1 -: DATA_W] : a_inc[ADDR_W-1 -: DATA_W];
         if (in_a1) begin
            n_oe = 1'b1;
            n_ad = a[DATA_W-1:0];
         end else if (in_a2) begin
            n_oe = 1'b1;
            n_ad = a_inc[DATA_W-1:0];
         end
      end else if (c.movc) begin
         n_hi = a[ADDR_W-1 -: DATA_W];
         if (in_a1) begin
            n_oe = 1'b1;
            n_ad = a[DATA_W-1:0];
         end
      end
   end

   generate
      if (REG_PINS) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               ale    <= 1'b0;
               psen_n <= 1'b1;
               rd_n   <= 1'b1;
               wr_n   <= 1'b1;
               ad_oe  <= 1'b0;
               ad_out <= '0;
               hi_out <= '0;
            end else begin
               ale    <= n_ale;
               psen_n <= n_psen_n;
               rd_n   <= n_rd_n;
               wr_n   <= n_wr_n;
               ad_oe  <= n_oe;
               ad_out <= n_ad;
               hi_out <= n_hi;
            end
         end
      end else begin : g_comb
         always_comb begin
            ale    = n_ale;
            psen_n = n_psen_n;
            rd_n   = n_rd_n;
            wr_n   = n_wr_n;
            ad_oe  = n_oe;
            ad_out = n_ad;
            hi_out = n_hi;
         end
      end
   endgenerate

   // R4
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(!rd_n && !wr_n));

   // R4
   code_data_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !psen_n |-> (rd_n && wr_n));

   // R8
   bus_float_chk: assert property (@(posedge clk) disable iff (rst)
      (!psen_n || !rd_n) |-> !ad_oe);

   // R3
   ale_min_width_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ale) |=> ale);

   // R3
   ale_strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
      ale |-> (psen_n && rd_n && wr_n));

endmodule

// File: rtl/xbus_capture.sv
module xbus_capture #(
   parameter  int STATE_CLKS = 2,
   parameter  int DATA_W     = 8,
   localparam int CYC        = 6 * STATE_CLKS,
   localparam int PW         = $clog2(CYC + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PW-1:0]     phase,
   input  logic              data_rd,
   input  logic              xfetch,
   input  logic              movc,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] rbyte,
   output logic              rbyte_vld
);

   localparam logic [PW-1:0] C_DATA = PW'(4 * STATE_CLKS + STATE_CLKS / 2 - 1);
   localparam logic [PW-1:0] C_CODE1 = PW'(3 * STATE_CLKS - 1);
   localparam logic [PW-1:0] C_CODE2 = PW'(CYC - 1);

   logic take;

   always_comb begin
      take = (data_rd && phase == C_DATA)
           || ((xfetch || movc) && phase == C_CODE1)
           || (xfetch && phase == C_CODE2);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rbyte     <= '0;
         rbyte_vld <= 1'b0;
      end else begin
         rbyte_vld <= take;
         if (take) rbyte <= ad_in;
      end
   end

   // R10
   vld_gap_chk: assert property (@(posedge clk) disable iff (rst)
      rbyte_vld |=> !rbyte_vld);

endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
   import xbus_pkg::*;
#(
   parameter  int STATE_CLKS = 2,
   parameter  int DATA_W     = 8,
   parameter  int ADDR_W     = 16,
   parameter  bit REG_PINS   = 1'b1,
   localparam int CYC        = 6 * STATE_CLKS,
   localparam int PW         = $clog2(CYC + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ext_exec,
   input  logic              ale_quiet,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] port_hi_latch,
   input  logic [DATA_W-1:0] ad_in,
   output logic              mc_sync,
   output logic              ale,
   output logic              psen_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [DATA_W-1:0] hi_out,
   output logic [DATA_W-1:0] rbyte,
   output logic              rbyte_vld
);

   generate
      if (STATE_CLKS < 2 || (STATE_CLKS % 2) != 0) begin : g_bad_state
         $error("STATE_CLKS must be even and at least 2");
      end
      if (ADDR_W != 2 * DATA_W) begin : g_bad_addr
         $error("ADDR_W must be twice DATA_W");
      end
   endgenerate

   logic [PW-1:0]     phase, phase_nxt;
   logic              wrap;
   xcyc_t             cyc_q, cyc_d;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic [DATA_W-1:0] wd_q, wd_d, p2_q, p2_d;

   xbus_phase #(.STATE_CLKS(STATE_CLKS)) u_phase (
      .clk(clk), .rst(rst), .phase(phase), .phase_nxt(phase_nxt),
      .wrap(wrap), .mc_sync(mc_sync)
   );

   xbus_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
      .clk(clk), .rst(rst), .wrap(wrap), .kind(req_kind),
      .quiet(ale_quiet), .ext(ext_exec), .addr(req_addr),
      .wdata(req_wdata), .p2(port_hi_latch),
      .cyc_q(cyc_q), .cyc_d(cyc_d), .addr_q(addr_q), .addr_d(addr_d),
      .wd_q(wd_q), .wd_d(wd_d), .p2_q(p2_q), .p2_d(p2_d)
   );

   xbus_pins #(.STATE_CLKS(STATE_CLKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
               .REG_PINS(REG_PINS)) u_pins (
      .clk(clk), .rst(rst), .phase(phase), .phase_nxt(phase_nxt),
      .cyc_q(cyc_q), .cyc_d(cyc_d), .addr_q(addr_q), .addr_d(addr_d),
      .wd_q(wd_q), .wd_d(wd_d), .p2_q(p2_q), .p2_d(p2_d),
      .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
      .ad_out(ad_out), .ad_oe(ad_oe), .hi_out(hi_out)
   );

   xbus_capture #(.STATE_CLKS(STATE_CLKS), .DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst(rst), .phase(phase),
      .data_rd(cyc_q.data & ~cyc_q.wr), .xfetch(cyc_q.xfetch),
      .movc(cyc_q.movc), .ad_in(ad_in),
      .rbyte(rbyte), .rbyte_vld(rbyte_vld)
   );

endmodule

// File: tb/xbus_sequencer_test.sv
`timescale 1ns/1ps
module xbus_sequencer_test;

   logic        clk = 1'b0;
   logic        rst;
   logic        ext_exec, ale_quiet;
   logic [2:0]  req_kind;
   logic [15:0] req_addr;
   logic [7:0]  req_wdata, port_hi_latch, ad_in;
   logic        mc_sync, ale, psen_n, rd_n, wr_n, ad_oe, rbyte_vld;
   logic [7:0]  ad_out, hi_out, rbyte;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit pend   = 1'b0;
   logic [7:0] pend_val = 8'h00;

   always #2.5 clk = ~clk;

   xbus_sequencer uut (
      .clk(clk), .rst(rst), .ext_exec(ext_exec), .ale_quiet(ale_quiet),
      .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
      .port_hi_latch(port_hi_latch), .ad_in(ad_in), .mc_sync(mc_sync),
      .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
      .ad_out(ad_out), .ad_oe(ad_oe), .hi_out(hi_out),
      .rbyte(rbyte), .rbyte_vld(rbyte_vld)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // expected {ale, psen_n, rd_n, wr_n} for slot s
   function automatic logic [3:0] exp_stb(input logic [2:0] k, input bit q,
                                          input bit e, input int s);
      bit data = k[2], wr = k[2] & k[1], xf = (k == 3'd1) && e;
      bit mv = (k == 3'd2), sup = q && !e;
      bit h1 = data || mv || !sup, h2 = !data && (mv || !sup);
      bit a  = ((s < 2) && h1) || ((s == 6 || s == 7) && h2);
      bit ps = (xf && ((s >= 3 && s <= 5) || s >= 9)) || (mv && s >= 3 && s <= 5);
      bit st = (s >= 3 && s <= 8);
      return {a, !ps, !(data && !wr && st), !(data && wr && st)};
   endfunction

   // expected {oe, ad}
   function automatic logic [8:0] exp_bus(input logic [2:0] k, input bit e,
                                          input logic [15:0] a,
                                          input logic [7:0] w, input int s);
      logic [15:0] ai = a + 16'd1;
      if (k[2]) begin
         if (s < 2) return {1'b1, a[7:0]};
         if (k[1] && s >= 2 && s <= 10) return {1'b1, w};
         return 9'h0;
      end
      if (k == 3'd1 && e) begin
         if (s < 2) return {1'b1, a[7:0]};
         if (s == 6 || s == 7) return {1'b1, ai[7:0]};
         return 9'h0;
      end
      if (k == 3'd2 && s < 2) return {1'b1, a[7:0]};
      return 9'h0;
   endfunction

   function automatic logic [7:0] exp_hi(input logic [2:0] k, input bit e,
                                         input logic [15:0] a,
                                         input logic [7:0] p, input int s);
      logic [15:0] ai = a + 16'd1;
      if (k == 3'd1 && e) return (s < 6) ? a[15:8] : ai[15:8];
      if (k == 3'd2 || (k[2] && k[0])) return a[15:8];
      return p;
   endfunction

   function automatic string stb_tag(input logic [2:0] k, input bit q, input bit e);
      if (k[2]) return "R4";
      if (k == 3'd2) return "R11";
      if (k == 3'd1 && e) return q ? "R7" : "R5";
      if (q && !e) return "R6";
      if (k == 3'd1) return "R12";
      return q ? "R7" : "R3";
   endfunction

   // called at the negedge inside slot 11 of the previous cycle
   task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                            input logic [7:0] w, input logic [7:0] p,
                            input bit q, input bit e, input logic [7:0] din);
      bit xf = (k == 3'd1) && e;
      req_kind = k; req_addr = a; req_wdata = w; port_hi_latch = p;
      ale_quiet = q; ext_exec = e;
      for (int s = 0; s < 12; s++) begin
         logic [3:0] es;
         logic [8:0] eb;
         logic [7:0] eh;
         bit ev;
         logic [7:0] evv;
         @(negedge clk);
         ad_in = din + 8'(s);
         es = exp_stb(k, q, e, s);
         eb = exp_bus(k, e, a, w, s);
         eh = exp_hi(k, e, a, p, s);
         chk(mc_sync == (s == 11), "R2", "mc_sync", 32'(mc_sync), 32'(s == 11));
         chk({ale, psen_n, rd_n, wr_n} == es, stb_tag(k, q, e), "strobes",
             32'({ale, psen_n, rd_n, wr_n}), 32'(es));
         chk(ad_oe == eb[8] && (!eb[8] || ad_out == eb[7:0]),
             (k == 3'd1 && !e) ? "R12" : "R8", "bus",
             32'({ad_oe, ad_out}), 32'(eb));
         chk(hi_out == eh, "R9", "hi_out", 32'(hi_out), 32'(eh));
         ev = 1'b0; evv = 8'h00;
         if (s == 0 && pend) begin ev = 1'b1; evv = pend_val; end
         if (s == 6 && (xf || k == 3'd2)) begin ev = 1'b1; evv = din + 8'd5; end
         if (s == 9 && k[2] && !k[1]) begin ev = 1'b1; evv = din + 8'd8; end
         chk(rbyte_vld == ev && (!ev || rbyte == evv), "R10", "rbyte",
             32'({rbyte_vld, rbyte}), 32'({ev, evv}));
         if (s == 11) begin
            pend = xf;
            pend_val = din + 8'd11;
         end
      end
   endtask

   initial begin
      void'($urandom(32'h1bad5eed));
      rst = 1'b1; ext_exec = 1'b0; ale_quiet = 1'b0; req_kind = 3'd0;
      req_addr = 16'h0; req_wdata = 8'h0; port_hi_latch = 8'h0; ad_in = 8'h0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         // R1 reset state
         chk(!ale && psen_n && rd_n && wr_n && !ad_oe && mc_sync && !rbyte_vld,
             "R1", "reset pins",
             32'({ale, psen_n, rd_n, wr_n, ad_oe, mc_sync, rbyte_vld}), 32'h3A);
      end
      rst = 1'b0;
      // directed corners
      run_cycle(3'd0, 16'h1234, 8'h00, 8'h5A, 1'b0, 1'b0, 8'h10); // R3
      run_cycle(3'd0, 16'h1234, 8'h00, 8'h5A, 1'b1, 1'b0, 8'h20); // R6
      run_cycle(3'd1, 16'h12FF, 8'h00, 8'h5A, 1'b1, 1'b1, 8'h30); // R5 R7 carry
      run_cycle(3'd1, 16'h4000, 8'h00, 8'h66, 1'b0, 1'b0, 8'h40); // R12
      run_cycle(3'd1, 16'h4000, 8'h00, 8'h66, 1'b1, 1'b0, 8'h50); // R6
      run_cycle(3'd2, 16'h8A10, 8'h00, 8'h66, 1'b1, 1'b0, 8'h60); // R11
      run_cycle(3'd4, 16'h3C77, 8'h00, 8'hA5, 1'b1, 1'b0, 8'h70); // R9 latch
      run_cycle(3'd5, 16'hBEEF, 8'h00, 8'hA5, 1'b0, 1'b1, 8'h80); // R4
      run_cycle(3'd6, 16'h3C77, 8'hC3, 8'h17, 1'b0, 1'b0, 8'h90); // R8
      run_cycle(3'd7, 16'hFFFF, 8'h3C, 8'h17, 1'b1, 1'b1, 8'hA0); // R4
      run_cycle(3'd3, 16'h0001, 8'h00, 8'h99, 1'b0, 1'b1, 8'hB0); // reserved
      run_cycle(3'd1, 16'hFFFF, 8'h00, 8'h99, 1'b0, 1'b1, 8'hC0); // R10
      run_cycle(3'd4, 16'h0020, 8'h00, 8'h44, 1'b0, 1'b1, 8'hD0); // R10 slot0
      // seeded random mix
      for (int n = 0; n < 90; n++) begin
         run_cycle(3'($urandom % 8), 16'($urandom), 8'($urandom), 8'($urandom),
                   1'($urandom % 2), 1'($urandom % 2), 8'($urandom));
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule